// File: doc/BRIEF.md
# GPIO Runtime Port Bank

This block holds the runtime registers of a 32-pin general-purpose I/O unit. The pins are grouped into four 8-bit ports. A host reaches them through a simple byte-wide read/write bus. Each port has three kinds of register:

- a latch that drives the output pins;
- a view of the synchronised input pins;
- on the two lower ports only, an edge-event enable register and a sticky event status register.

The bank answers inside a 16-byte window. The window's base address and an activation flag come from configuration logic elsewhere in the chip. While the flag is low, the bank ignores the bus completely.

The port windows are not evenly spaced. Ports 0 and 1 each use four bytes. Port 2 is cut short to two bytes by port 3, which follows it directly. An interrupt line reports any pending event whose enable bit is set. Host software works with linear pin numbers: bits [4:3] of the number select the port and bits [2:0] select the bit inside it.

Top module: `gpio_port_bank`

## Requirements
- R1: An access hits the bank only when `unitActive` is 1 and `busAddr[15:4]` equals `baseAddr[15:4]`; the low four bits of `baseAddr` are ignored. A write that misses changes nothing. A read that misses returns 0x00.
- R2: Window layout by offset `busAddr[3:0]`:
  - Port 0 sits at 0..3 and port 1 at 4..7, each ordered output, input, event enable, event status.
  - Port 2 has its output at 8 and its input at 9.
  - Port 3 has its output at 10 and its input at 11.
  - Offsets 12..15 read 0x00 and ignore writes.
- R3: A write to a port's output register drives `pinOut[8p+7:8p]` from the next clock edge on. The register reads back the value written, so pin n appears on `pinOut[n]`. Writes to input offsets are ignored.
- R4: An input-offset read returns `pinIn` after a two-flop synchroniser. A pin change first set up before edge k is returned by a read captured at edge k+2, but not by one captured at edge k+1.
- R5: On ports 0 and 1, a rising edge of a synchronised pin sets its status bit when its enable bit is 1. A falling edge, or a rising edge with the enable bit at 0, leaves the status bit unchanged.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: `evtIrq` is the OR of all status bits whose enable bit is 1. Clearing an enable bit masks `evtIrq` without clearing the status bit. Without a bus write, an asserted `evtIrq` stays asserted.
- R8: Pins 16..31 never set any status bit and never raise `evtIrq`.
- R9: After reset:
  - all output registers, enables and status bits are 0x00;
  - `pinOut` is 0;
  - `evtIrq` is 0.
- R10: `busRdata` is registered. It is loaded at the edge where `busRd` is 1 and holds its value while `busRd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseAddr | input | 16 | Window base address (16-byte aligned, low bits ignored) |
| unitActive | input | 1 | Bank responds only while 1 |
| busAddr | input | 16 | Bus byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| pinIn | input | 32 | Pin levels, asynchronous |
| pinOut | output | 32 | Output latch levels |
| evtIrq | output | 1 | Event interrupt |

## Verification
Errors show up at the ports, each within one or two cycles:

- **Wrong offset decode.** A write lands in the wrong byte of `pinOut`, or a read returns another register's value. Both appear one cycle after the access.
- **Wrong synchroniser depth.** The cycle in which a new pin level first becomes readable moves.
- **Wrong edge detection or clear logic.** Status readback and `evtIrq` disagree with the pin history two edges after the pin moves, or one edge after the clearing write.
- **Leak into the event-less ports.** The interrupt rises while only the upper pins toggle.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int GPB_WIN_BITS = 4;
  localparam int GPB_PIDX_W   = 2;

  typedef enum logic [2:0] {RK_NONE, RK_OUT, RK_IN, RK_EN, RK_ST} regKind_e;

  typedef struct packed {
    logic                  wr;
    logic                  rd;
    regKind_e              kind;
    logic [GPB_PIDX_W-1:0] port;
  } bankStrobe_t;

  function automatic regKind_e kindOf(input logic [1:0] sub);
    case (sub)
      2'd0:    return RK_OUT;
      2'd1:    return RK_IN;
      2'd2:    return RK_EN;
      default: return RK_ST;
    endcase
  endfunction
endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int NUM_EVT_PORTS = 2
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              unitActive,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output bankStrobe_t       strobe
);
  logic                   hit;
  logic [GPB_WIN_BITS-1:0] ofs;
  regKind_e               kind;
  logic [GPB_PIDX_W-1:0]  port;

  assign hit = unitActive &&
               (busAddr[ADDR_W-1:GPB_WIN_BITS] == baseAddr[ADDR_W-1:GPB_WIN_BITS]);
  assign ofs = busAddr[GPB_WIN_BITS-1:0];

  // Uneven layout: 0..7 two full ports, 8..9 short port 2, 10..13 port 3.
  always_comb begin
    port = '0;
    kind = RK_NONE;
    if (ofs < 4'd8) begin
      port = ofs[3:2];
      kind = kindOf(ofs[1:0]);
    end else if (ofs < 4'd10) begin
      port = 2'd2;
      kind = ofs[0] ? RK_IN : RK_OUT;
    end else if (ofs < 4'd14) begin
      port = 2'd3;
      kind = kindOf(2'(ofs - 4'd10));
    end
    if ((kind == RK_EN || kind == RK_ST) && int'(port) >= NUM_EVT_PORTS)
      kind = RK_NONE;
    if (!hit)
      kind = RK_NONE;
  end

  always_comb begin
    strobe.wr   = busWr && (kind != RK_NONE) && (kind != RK_IN);
    strobe.rd   = busRd;
    strobe.kind = kind;
    strobe.port = port;
  end
endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int NUM_PORTS     = 4,
  parameter int NUM_EVT_PORTS = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t                 strobe,
  input  logic [PORT_W-1:0]           wdata,
  input  logic [PORT_W*NUM_PORTS-1:0] pinIn,
  output logic [PORT_W*NUM_PORTS-1:0] pinOut,
  output logic [PORT_W-1:0]           rdata,
  output logic                        irq
);
  localparam int PIN_W = PORT_W * NUM_PORTS;
  localparam int EVT_W = PORT_W * NUM_EVT_PORTS;

  logic [PIN_W-1:0]  syncQ [SYNC_STAGES];
  logic [PIN_W-1:0]  pinLvl;
  logic [EVT_W-1:0]  prevLvl;
  logic [PORT_W-1:0] outView [NUM_PORTS];
  logic [PORT_W-1:0] enView  [NUM_EVT_PORTS];
  logic [PORT_W-1:0] stView  [NUM_EVT_PORTS];
  logic [NUM_EVT_PORTS-1:0] irqVec;
  logic [PORT_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevLvl <= pinLvl[EVT_W-1:0];
    end
  end
  assign pinLvl = syncQ[SYNC_STAGES-1];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gOut
    logic [PORT_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (strobe.wr && strobe.kind == RK_OUT && strobe.port == GPB_PIDX_W'(p))
        q <= wdata;
    end
    assign outView[p] = q;
    assign pinOut[p*PORT_W +: PORT_W] = q;
  end

  for (genvar e = 0; e < NUM_EVT_PORTS; e++) begin : gEvt
    logic [PORT_W-1:0] enQ, stQ, rise, clrMask;
    logic              sel;
    assign sel     = strobe.wr && strobe.port == GPB_PIDX_W'(e);
    assign rise    = pinLvl[e*PORT_W +: PORT_W] & ~prevLvl[e*PORT_W +: PORT_W] & enQ;
    assign clrMask = (sel && strobe.kind == RK_ST) ? wdata : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ <= '0;
        stQ <= '0;
      end else begin
        if (sel && strobe.kind == RK_EN) enQ <= wdata;
        stQ <= (stQ & ~clrMask) | rise;
      end
    end
    assign enView[e] = enQ;
    assign stView[e] = stQ;
    assign irqVec[e] = |(stQ & enQ);
  end

  assign irq = |irqVec;

  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe.port == GPB_PIDX_W'(p)) begin
        if (strobe.kind == RK_OUT) rdNext = outView[p];
        if (strobe.kind == RK_IN)  rdNext = pinLvl[p*PORT_W +: PORT_W];
      end
    end
    for (int e = 0; e < NUM_EVT_PORTS; e++) begin
      if (strobe.port == GPB_PIDX_W'(e)) begin
        if (strobe.kind == RK_EN) rdNext = enView[e];
        if (strobe.kind == RK_ST) rdNext = stView[e];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdata <= '0;
    else if (strobe.rd)
      rdata <= rdNext;
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpb_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int PORT_W        = 8,
  parameter int NUM_PORTS     = 4,
  parameter int NUM_EVT_PORTS = 2,
  parameter int SYNC_STAGES   = 2,
  localparam int PIN_W        = PORT_W * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              unitActive,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic              evtIrq
);
  bankStrobe_t strobe;

  gpb_ctrl #(.ADDR_W(ADDR_W), .NUM_EVT_PORTS(NUM_EVT_PORTS)) u_ctrl (
    .baseAddr(baseAddr), .unitActive(unitActive), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strobe(strobe)
  );

  gpb_datapath #(
    .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS),
    .NUM_EVT_PORTS(NUM_EVT_PORTS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .pinIn(pinIn), .pinOut(pinOut), .rdata(busRdata), .irq(evtIrq)
  );
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int PIN_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              unitActive,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [PORT_W-1:0] busWdata,
  input logic [PORT_W-1:0] busRdata,
  input logic [PIN_W-1:0]  pinOut,
  input logic              evtIrq
);
  logic inWin;
  assign inWin = unitActive && (busAddr[ADDR_W-1:4] == baseAddr[ADDR_W-1:4]);

  AST_MISS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !inWin) |=> $stable(pinOut)); // R1
  AST_MISS_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !inWin) |=> (busRdata == '0)); // R1
  AST_OUT0_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && inWin && busAddr[3:0] == 4'd0) |=> (pinOut[PORT_W-1:0] == $past(busWdata))); // R3
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(pinOut)); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evtIrq && !busWr) |=> evtIrq); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata)); // R10
endmodule

bind gpio_port_bank gpb_checker #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .unitActive(unitActive),
  .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
  .busRdata(busRdata), .pinOut(pinOut), .evtIrq(evtIrq)
);

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0A47;
  localparam logic [15:0] WB   = 16'h0A40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baseAddr = BASE;
  logic        unitActive = 1'b1;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic        evtIrq;

  int vectors = 0, miscompares = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_bank u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .unitActive(unitActive),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .evtIrq(evtIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrA(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdA(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    wrA(WB + 16'(o), d);
  endtask

  task automatic rd(input logic [3:0] o, input logic [7:0] e, input string tag);
    rdA(WB + 16'(o), e, tag);
  endtask

  // monitor: read data appears the negedge after busRd was sampled
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tagQ.pop_front(), 32'(busRdata), 32'(expQ.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 pinOut after reset", pinOut, 32'h0);
    chk("R9 evtIrq after reset", 32'(evtIrq), 32'h0);
    rd(4'd0, 8'h00, "R9 port0 out reset");
    rd(4'd2, 8'h00, "R9 port0 enable reset");
    rd(4'd7, 8'h00, "R9 port1 status reset");

    // R2 R3 output registers and layout
    wr(4'd0, 8'hA5); wr(4'd4, 8'h3C); wr(4'd8, 8'h08); wr(4'd10, 8'hC1);
    chk("R3 R2 pinOut mapping", pinOut, 32'hC108_3CA5);
    chk("R3 pin19 is port2 bit3", 32'(pinOut[19]), 32'h1);
    rd(4'd0, 8'hA5, "R3 port0 readback");
    rd(4'd4, 8'h3C, "R3 R2 port1 readback");
    rd(4'd8, 8'h08, "R3 R2 port2 readback");
    rd(4'd10, 8'hC1, "R3 R2 port3 readback");
    wr(4'd1, 8'hFF);
    chk("R3 write to input offset ignored", pinOut, 32'hC108_3CA5);

    // R1 window decode
    unitActive = 1'b0;
    wr(4'd0, 8'hFF);
    chk("R1 inactive write ignored", pinOut, 32'hC108_3CA5);
    rd(4'd0, 8'h00, "R1 inactive read zero");
    unitActive = 1'b1;
    wrA(WB + 16'h0010, 8'hFF);
    chk("R1 out-of-window write ignored", pinOut, 32'hC108_3CA5);
    rdA(WB - 16'h0010, 8'h00, "R1 out-of-window read zero");
    rdA(WB + 16'h000F, 8'h00, "R1 R2 offset 15 reads zero");

    // R4 synchroniser latency then values
    @(negedge clk);
    pinIn = 32'h5A3C_C381;
    rd(4'd1, 8'h00, "R4 read at edge k+1 still old");
    rd(4'd1, 8'h81, "R4 port0 input");
    rd(4'd5, 8'hC3, "R4 R2 port1 input");
    rd(4'd9, 8'h3C, "R4 R2 port2 input");
    rd(4'd11, 8'h5A, "R4 R2 port3 input");

    // R2 R8 port3 has no event registers
    wr(4'd12, 8'hFF); wr(4'd13, 8'hFF);
    rd(4'd12, 8'h00, "R8 R2 offset 12 reads zero");
    rd(4'd13, 8'h00, "R8 R2 offset 13 reads zero");
    rd(4'd10, 8'hC1, "R2 port3 out untouched");
    rd(4'd14, 8'h00, "R2 offset 14 reads zero");

    // R10 hold
    rd(4'd0, 8'hA5, "R10 load");
    repeat (3) @(negedge clk);
    chk("R10 rdata holds while idle", 32'(busRdata), 32'hA5);

    // events
    pinIn = 32'h0;
    repeat (4) @(negedge clk);
    wr(4'd2, 8'h01);
    pinIn = 32'h0000_0003;
    repeat (4) @(negedge clk);
    chk("R5 R7 irq after enabled rise", 32'(evtIrq), 32'h1);
    rd(4'd3, 8'h01, "R5 only enabled bit set");
    pinIn = 32'h0;
    repeat (4) @(negedge clk);
    wr(4'd3, 8'h00);
    rd(4'd3, 8'h01, "R6 writing zero keeps status");
    wr(4'd3, 8'h01);
    rd(4'd3, 8'h00, "R6 writing one clears status");
    chk("R7 irq low after clear", 32'(evtIrq), 32'h0);

    wr(4'd6, 8'h80);
    pinIn = 32'h0000_8000;
    repeat (4) @(negedge clk);
    rd(4'd7, 8'h80, "R5 port1 pin15 rise");
    chk("R7 irq from port1", 32'(evtIrq), 32'h1);
    wr(4'd6, 8'h00);
    chk("R7 irq masked by enable", 32'(evtIrq), 32'h0);
    rd(4'd7, 8'h80, "R7 status kept when masked");
    wr(4'd7, 8'h80);
    rd(4'd7, 8'h00, "R6 port1 clear");

    // R8 upper pins never raise events
    wr(4'd2, 8'hFF); wr(4'd6, 8'hFF);
    pinIn = 32'hFFFF_8000;
    repeat (5) @(negedge clk);
    chk("R8 upper pins no irq", 32'(evtIrq), 32'h0);
    rd(4'd3, 8'h00, "R8 port0 status clear");
    rd(4'd7, 8'h00, "R8 port1 status clear");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule